// File: doc/BRIEF.md
# Event Timer Register Front End and Main Counter

This block is the software-facing register window and the 64-bit free-running main counter of a high-precision event timer with a small set of comparator channels. A 32-bit access port decodes a 1 KiB byte-addressed window. The low 256 bytes hold the global registers: capability and tick period, general configuration, interrupt status and the two counter halves. Above offset 0x100 the window is split into 32-byte channel slots. Accesses to those slots go to the separate comparator channels, and their read data comes back from them.

The general configuration holds two bits: a global enable and a legacy-route flag. The counter advances on each qualified tick while the enable is set, and it keeps its value while the enable is clear. Software can rewrite either 32-bit half of the counter. When the enable turns on, the block sends a one-cycle arm pulse to every channel whose comparator is not at its all-ones idle value. When the legacy flag turns on or off, the block sends a one-cycle pulse that tells the legacy interval timer and the real-time-clock interrupt source to release or retake their lines.

Top module: `evt_timer_regs`

## Requirements
- R1: Reading offset 0x000 returns the capability word {vendor[15:0], bit15=1 legacy-route capable, bit14=0, bit13=1 64-bit counter, bits12:8 = channel count minus one, bits7:0 = 0x01}, which is 0x8086A201 with three channels. Offset 0x004 returns the tick period in femtoseconds.
- R2: Writes to offsets 0x000 and 0x004 have no effect on what those offsets read.
- R3: The configuration word at 0x010 holds enable in bit 0 and legacy-route in bit 1. All its other bits read zero, and offset 0x014 reads zero and ignores writes.
- R4: During and after reset the counter, enable, legacy flag, all pulses and the read data are zero.
- R5: While enabled, the counter rises by exactly one in each cycle with tick_en high, including the carry from the low half into the high half. While disabled, or with tick_en low, it holds its value.
- R6: A write to 0x0F0 replaces only counter bits 31:0, and a write to 0x0F4 replaces only bits 63:32. Reads of 0x0F0 and 0x0F4 return the current count halves.
- R7: A configuration write that takes the enable from 0 to 1 raises ch_arm[i] for exactly one cycle, in the cycle glb_en rises, for each channel i whose ch_cmp_unset[i] is low. Any other configuration write leaves ch_arm zero.
- R8: legacy_route follows config bit 1. A 0-to-1 change of that bit gives a one-cycle legacy_release pulse, and a 1-to-0 change gives a one-cycle legacy_reclaim pulse. Both pulses appear together with the new level.
- R9: Offset 0x020 reads the channel interrupt-pending bits, zero-extended. Writes to it have no effect.
- R10: Offsets 0x100 + 32*n + k address channel slot n at byte offset k. For n below the channel count, a write raises only ch_wr[n] with ch_off = k, and a read returns channel n's read word. For slots n at or above the channel count, reads return zero and writes raise no strobe.
- R11: Read data is registered: bus_rdata changes on the clock edge that samples bus_rd and holds otherwise. Unmapped offsets below 0x100 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Counter tick qualifier |
| irq_pend | input | NUM_CH | Channel interrupt-pending bits |
| ch_rdata | input | 32*NUM_CH | Read words from the channels |
| ch_cmp_unset | input | NUM_CH | Channel comparator is all ones |
| ch_wr | output | NUM_CH | Per-channel write strobe |
| ch_off | output | 5 | Byte offset within channel slot |
| ch_wdata | output | 32 | Write data to channels |
| count | output | 64 | Main counter value |
| glb_en | output | 1 | Global enable |
| legacy_route | output | 1 | Legacy-route flag |
| legacy_release | output | 1 | Pulse: legacy timers give up their lines |
| legacy_reclaim | output | 1 | Pulse: legacy timers retake their lines |
| ch_arm | output | NUM_CH | One-cycle arm pulse per channel |

## Verification
Configuration, counter-half writes, the enable and legacy levels and their arm, release and reclaim pulses all take effect on the edge that samples the write strobe. The bench therefore checks them at the falling edge right after that write cycle, and checks again one cycle later that each pulse has dropped. Read data is due on the edge that samples the read strobe and is checked at the next falling edge. Channel write strobes and offsets are combinational forwards, so they are sampled in the middle of the write cycle. Counter growth is checked after a known number of falling edges with tick_en held high, using a start value that forces a carry into the upper half.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int ADDR_W     = 10;
    localparam int SLOT_LG2   = 5;
    localparam int SLOT_W     = ADDR_W - SLOT_LG2;
    localparam int CNT_W      = 64;
    localparam int WORD_W     = 32;

    localparam logic [ADDR_W-1:0] OFS_CAP    = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_CFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 10'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
    localparam logic [ADDR_W-1:0] CH_BASE    = 10'h100;

    localparam int CFG_EN_BIT  = 0;
    localparam int CFG_LEG_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_PERIOD,
        SEL_CFG,
        SEL_STATUS,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_CHAN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [SLOT_W-1:0]   slot;
        logic [SLOT_LG2-1:0] off;
    } reg_dec_t;

    function automatic logic [WORD_W-1:0] cap_word(input int nch,
                                                   input logic [15:0] vendor);
        logic [4:0] last_ch;
        last_ch = 5'(nch - 1);
        return {vendor, 1'b1, 1'b0, 1'b1, last_ch, 8'h01};
    endfunction

endpackage

// File: rtl/evt_regdec.sv
module evt_regdec
    import evt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_dec_t          dec
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel      = addr - CH_BASE;
        dec.sel  = SEL_NONE;
        dec.slot = '0;
        dec.off  = addr[SLOT_LG2-1:0];
        if (addr >= CH_BASE) begin
            dec.sel  = SEL_CHAN;
            dec.slot = rel[ADDR_W-1:SLOT_LG2];
        end else begin
            unique case (addr)
                OFS_CAP:    dec.sel = SEL_CAP;
                OFS_PERIOD: dec.sel = SEL_PERIOD;
                OFS_CFG:    dec.sel = SEL_CFG;
                OFS_STATUS: dec.sel = SEL_STATUS;
                OFS_CNT_LO: dec.sel = SEL_CNT_LO;
                OFS_CNT_HI: dec.sel = SEL_CNT_HI;
                default:    dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    localparam int HALF = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[HALF-1:0] <= wdata[HALF-1:0];
        end else if (wr_hi) begin
            cnt_q[CNT_W-1:HALF] <= wdata[HALF-1:0];
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/evt_gcfg.sv
module evt_gcfg
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NUM_CH-1:0] cmp_unset,
    output logic              en,
    output logic              leg,
    output logic [NUM_CH-1:0] arm,
    output logic              leg_release,
    output logic              leg_reclaim
);
    logic              en_q, leg_q, rel_q, rcl_q;
    logic              en_n, leg_n;
    logic [NUM_CH-1:0] arm_q;

    always_comb begin
        en_n  = cfg_wr ? wdata[CFG_EN_BIT]  : en_q;
        leg_n = cfg_wr ? wdata[CFG_LEG_BIT] : leg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            leg_q <= 1'b0;
            arm_q <= '0;
            rel_q <= 1'b0;
            rcl_q <= 1'b0;
        end else begin
            en_q  <= en_n;
            leg_q <= leg_n;
            arm_q <= (en_n && !en_q) ? ~cmp_unset : '0;
            rel_q <= leg_n && !leg_q;
            rcl_q <= !leg_n && leg_q;
        end
    end

    assign en          = en_q;
    assign leg         = leg_q;
    assign arm         = arm_q;
    assign leg_release = rel_q;
    assign leg_reclaim = rcl_q;
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
    import evt_pkg::*;
#(
    parameter int          NUM_CH    = 3,
    parameter logic [31:0] TICK_FS   = 32'h05F5_E100,
    parameter logic [15:0] VENDOR_ID = 16'h8086
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [9:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic                     tick_en,
    input  logic [NUM_CH-1:0]        irq_pend,
    input  logic [32*NUM_CH-1:0]     ch_rdata,
    input  logic [NUM_CH-1:0]        ch_cmp_unset,
    output logic [NUM_CH-1:0]        ch_wr,
    output logic [4:0]               ch_off,
    output logic [31:0]              ch_wdata,
    output logic [63:0]              count,
    output logic                     glb_en,
    output logic                     legacy_route,
    output logic                     legacy_release,
    output logic                     legacy_reclaim,
    output logic [NUM_CH-1:0]        ch_arm
);
    localparam logic [WORD_W-1:0] CAP = cap_word(NUM_CH, VENDOR_ID);

    reg_dec_t          dec;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] chan_word;
    logic [WORD_W-1:0] rdata_q;

    evt_regdec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    evt_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (glb_en),
        .tick  (tick_en),
        .wr_lo (bus_wr && dec.sel == SEL_CNT_LO),
        .wr_hi (bus_wr && dec.sel == SEL_CNT_HI),
        .wdata (bus_wdata),
        .count (count)
    );

    evt_gcfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (bus_wr && dec.sel == SEL_CFG),
        .wdata       (bus_wdata),
        .cmp_unset   (ch_cmp_unset),
        .en          (glb_en),
        .leg         (legacy_route),
        .arm         (ch_arm),
        .leg_release (legacy_release),
        .leg_reclaim (legacy_reclaim)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chwr
            assign ch_wr[g] = bus_wr && dec.sel == SEL_CHAN
                              && dec.slot == SLOT_W'(g);
        end
    endgenerate

    assign ch_off   = dec.off;
    assign ch_wdata = bus_wdata;

    always_comb begin
        chan_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dec.slot == SLOT_W'(i)) chan_word = ch_rdata[32*i +: 32];
        end
    end

    always_comb begin
        unique case (dec.sel)
            SEL_CAP:    rd_mux = CAP;
            SEL_PERIOD: rd_mux = TICK_FS;
            SEL_CFG:    rd_mux = {30'b0, legacy_route, glb_en};
            SEL_STATUS: rd_mux = WORD_W'(irq_pend);
            SEL_CNT_LO: rd_mux = count[31:0];
            SEL_CNT_HI: rd_mux = count[63:32];
            SEL_CHAN:   rd_mux = chan_word;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/evt_timer_regs_chk.sv
module evt_timer_regs_chk
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [9:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              tick_en,
    input logic [63:0]       count,
    input logic              glb_en,
    input logic              legacy_route,
    input logic              legacy_release,
    input logic              legacy_reclaim,
    input logic [NUM_CH-1:0] ch_wr,
    input logic [NUM_CH-1:0] ch_arm
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == OFS_CNT_LO || bus_addr == OFS_CNT_HI);

    // R4
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == 64'd0 && !glb_en && !legacy_route && ch_arm == '0));

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (glb_en && tick_en && !cnt_wr) |=> count == $past(count) + 64'd1);

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !cnt_wr) |=> $stable(count));

    // R6
    low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CNT_LO) |=>
        (count[31:0] == $past(bus_wdata) && count[63:32] == $past(count[63:32])));

    // R7
    arm_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_arm != '0) |-> (glb_en && !$past(glb_en)));

    // R8
    release_edge_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_release |-> (legacy_route && !$past(legacy_route)));

    // R8
    reclaim_edge_chk: assert property (@(posedge clk) disable iff (rst)
        legacy_reclaim |-> (!legacy_route && $past(legacy_route)));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_wr));
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .tick_en        (tick_en),
    .count          (count),
    .glb_en         (glb_en),
    .legacy_route   (legacy_route),
    .legacy_release (legacy_release),
    .legacy_reclaim (legacy_reclaim),
    .ch_wr          (ch_wr),
    .ch_arm         (ch_arm)
);

// File: tb/evt_timer_regs_tb.sv
module evt_timer_regs_tb;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              tick_en = 1'b0;
    logic [NCH-1:0]    irq_pend = '0;
    logic [32*NCH-1:0] ch_rdata;
    logic [NCH-1:0]    ch_cmp_unset = '0;
    logic [NCH-1:0]    ch_wr;
    logic [4:0]        ch_off;
    logic [31:0]       ch_wdata;
    logic [63:0]       count;
    logic              glb_en, legacy_route, legacy_release, legacy_reclaim;
    logic [NCH-1:0]    ch_arm;

    int nchk = 0;
    int nerr = 0;
    logic [NCH-1:0] seen_wr;
    logic [4:0]     seen_off;
    logic [31:0]    rv;
    logic [63:0]    cexp;

    always #4 clk = ~clk;

    evt_timer_regs u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq_pend(irq_pend), .ch_rdata(ch_rdata),
        .ch_cmp_unset(ch_cmp_unset), .ch_wr(ch_wr), .ch_off(ch_off),
        .ch_wdata(ch_wdata), .count(count), .glb_en(glb_en),
        .legacy_route(legacy_route), .legacy_release(legacy_release),
        .legacy_reclaim(legacy_reclaim), .ch_arm(ch_arm)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_rd
            assign ch_rdata[32*g +: 32] = 32'hA500_0000 | (32'(g) << 8) | 32'h5A;
        end
    endgenerate

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        #1;
        seen_wr = ch_wr; seen_off = ch_off;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] glob_exp(input logic [9:0] a, input logic [63:0] c,
                                             input logic [1:0] cfg);
        case (a)
            10'h000: return 32'h8086_A201;
            10'h004: return 32'h05F5_E100;
            10'h010: return {30'b0, cfg};
            10'h020: return 32'(irq_pend);
            10'h0F0: return c[31:0];
            10'h0F4: return c[63:32];
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 count", count, 64'd0);
        check("R4 en/leg", {62'd0, glb_en, legacy_route}, 64'd0);
        check("R4 pulses", {58'd0, legacy_release, legacy_reclaim, 1'b0, ch_arm}, 64'd0);
        check("R4 rdata", 64'(bus_rdata), 64'd0);
        rst = 1'b0;

        // R6: halves
        do_wr(10'h0F0, 32'h89AB_CDEF);
        do_wr(10'h0F4, 32'h0123_4567);
        check("R6 both halves", count, 64'h0123_4567_89AB_CDEF);
        do_wr(10'h0F0, 32'hFFFF_FFFF);
        check("R6 low only", count, 64'h0123_4567_FFFF_FFFF);
        do_wr(10'h0F4, 32'h0123_4567);
        check("R6 high only", count, 64'h0123_4567_FFFF_FFFF);

        // R1 R3 R6 R9 R11: global sweep
        irq_pend = 3'b101;
        for (int a = 0; a < 256; a += 4) begin
            do_rd(10'(a), rv);
            check($sformatf("R11 glob %03h", a), 64'(rv),
                  64'(glob_exp(10'(a), count, 2'b00)));
        end
        // R11: rdata holds without a read
        repeat (3) @(negedge clk);
        check("R11 hold", 64'(bus_rdata), 64'(glob_exp(10'h0FC, count, 2'b00)));

        // R2 R9 R3: ignored writes
        do_wr(10'h000, 32'h0);
        do_wr(10'h004, 32'h0);
        do_wr(10'h020, 32'hFFFF_FFFF);
        do_wr(10'h014, 32'hFFFF_FFFF);
        do_rd(10'h000, rv); check("R2 cap", 64'(rv), 64'h8086_A201);
        do_rd(10'h004, rv); check("R2 period", 64'(rv), 64'h05F5_E100);
        do_rd(10'h020, rv); check("R9 status", 64'(rv), 64'h5);
        do_rd(10'h014, rv); check("R3 cfg hi", 64'(rv), 64'h0);
        do_wr(10'h010, 32'hFFFF_FFFC);
        do_rd(10'h010, rv); check("R3 cfg masked", 64'(rv), 64'h0);
        check("R7 no arm on zero", 64'(ch_arm), 64'h0);

        // R7: enable edge arms channels not at idle
        ch_cmp_unset = 3'b010;
        do_wr(10'h010, 32'h1);
        check("R7 en level", 64'(glb_en), 64'h1);
        check("R7 arm", 64'(ch_arm), 64'h5);
        check("R8 no release", 64'(legacy_release), 64'h0);
        @(negedge clk);
        check("R7 arm one cycle", 64'(ch_arm), 64'h0);

        // R5: enabled, no tick -> hold; then 5 ticks with carry
        cexp = 64'h0123_4567_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R5 no tick", count, cexp);
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        check("R5 five ticks carry", count, cexp + 64'd5);
        do_rd(10'h0F4, rv); check("R6 read hi live", 64'(rv), 64'h0123_4568);
        do_rd(10'h0F0, rv); check("R6 read lo live", 64'(rv), 64'h4);

        // R7: write while already enabled gives no arm
        do_wr(10'h010, 32'h1);
        check("R7 no re-arm", 64'(ch_arm), 64'h0);

        // R8: legacy edges
        do_wr(10'h010, 32'h3);
        check("R8 route", 64'(legacy_route), 64'h1);
        check("R8 release", 64'({legacy_release, legacy_reclaim}), 64'h2);
        @(negedge clk);
        check("R8 release one cycle", 64'(legacy_release), 64'h0);
        do_rd(10'h010, rv); check("R3 cfg both", 64'(rv), 64'h3);
        do_wr(10'h010, 32'h1);
        check("R8 reclaim", 64'({legacy_route, legacy_release, legacy_reclaim}), 64'h1);
        @(negedge clk);
        check("R8 reclaim one cycle", 64'(legacy_reclaim), 64'h0);

        // R5: disabled -> frozen with ticks
        do_wr(10'h010, 32'h0);
        cexp = count;
        tick_en = 1'b1;
        repeat (4) @(negedge clk);
        tick_en = 1'b0;
        check("R5 frozen", count, cexp);
        check("R7 no arm on disable", 64'(ch_arm), 64'h0);

        // R10: channel slot sweep
        for (int s = 0; s < 24; s++) begin
            for (int k = 0; k <= 16; k += 4) begin
                logic [9:0] a;
                a = 10'h100 + 10'(s * 32 + k);
                do_rd(a, rv);
                check($sformatf("R10 rd slot%0d+%0d", s, k), 64'(rv),
                      (s < NCH) ? 64'(32'hA500_005A | (32'(s) << 8)) : 64'h0);
                do_wr(a, 32'(s * 32 + k));
                check($sformatf("R10 wr slot%0d+%0d", s, k), 64'(seen_wr),
                      (s < NCH) ? 64'(1 << s) : 64'h0);
                if (s < NCH) check("R10 off", 64'(seen_off), 64'(k));
            end
        end
        check("R10 count untouched", count, cexp);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule